// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block brings a memory card from power-up to a usable state over a four-wire SPI link. It owns the card's supply enable. After a controller reset, or after a pulse on `start`, it first removes card power for a set number of clocks. A card has no reset pin, so this is the only way to return it to a known state. The block then sends a run of idle clocks with chip select high. After that it issues the command chain that switches the card into SPI mode, checks the supply voltage, waits until the card leaves its idle state, and reads the operating-condition register.

All traffic moves as whole bytes in SPI mode 0, most significant bit first. The clock is divided from the system clock to an initialization-safe rate. While the card has not yet replied, the block keeps clocking out all-ones bytes and treats a missing reply as a fault. When the sequence ends, exactly one of `ready` and `error` is high and stays high until the next restart. When `ready` is high, `sdhc` gives the capacity class reported by the card.

Top module: `sd_spi_init`

## Requirements
- R1: After reset release or a `start` pulse, `pwr_en` stays low for at least PWR_OFF_CYC clocks. While it is low, `cs_n` is high and `sclk` is low. Afterwards `pwr_en` is high, and `cs_n` is never low while `pwr_en` is low.
- R2: Before the first command after power returns, at least SPARE_CLKS rising `sclk` edges occur with `cs_n` and `mosi` both high. `mosi` is high whenever `cs_n` is high.
- R3: Every command is six bytes sent with `cs_n` low, mode 0, most significant bit first: 0x40 OR the index, a 32-bit argument with the most significant byte first, then a check byte. The reset command is exactly 40 00 00 00 00 95.
- R4: The command order is index 0, then index 8 (exactly 48 00 00 01 AA 87), then pairs of index 55 and index 41 (argument 0x40000000, high-capacity bit 30 set), then index 58.
- R5: While waiting for a reply, the block sends 0xFF bytes. The first byte other than 0xFF is the status byte. If POLL_LIMIT bytes pass with no such byte, `error` is raised.
- R6: The status byte after index 0 must be 0x01, otherwise `error`.
- R7: After index 8, the status byte must be 0x01 and the four following bytes must be exactly 00 00 01 AA, otherwise `error`.
- R8: After index 41, status 0x00 moves on to index 58. Status 0x01 repeats index 55 and index 41, with at most ACMD_TRIES attempts of index 41 in total. When the attempts run out, or on any other status, `error` is raised. After index 55, status 0x00 or 0x01 is accepted.
- R9: After index 58, the status byte must be 0x00. Bit 30 of the following 32-bit register (bit 6 of its first byte) drives `sdhc`. The block then raises `cs_n`, gives exactly 8 more `sclk` cycles, and raises `ready`.
- R10: `ready` and `error` are never high together, and each stays high until restart. While either is high, `cs_n` is high and `sclk` stays low.
- R11: A `start` pulse discards all results. On the next clock `ready`, `error` and `sdhc` are low and `pwr_en` is low, and the sequence runs again from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous controller reset |
| start | input | 1 | Restart pulse: power-cycle the card and initialize again |
| miso | input | 1 | Serial data from the card |
| sclk | output | 1 | Divided serial clock to the card, idle low |
| cs_n | output | 1 | Active-low card select |
| mosi | output | 1 | Serial data to the card |
| pwr_en | output | 1 | Card supply enable |
| ready | output | 1 | Initialization finished successfully |
| error | output | 1 | Initialization failed |
| sdhc | output | 1 | Card reports high-capacity addressing |

## Verification
The assertions check the port-level invariants on every cycle. These are the quiet bus during power-off, `mosi` high while deselected, the clearing effect of `start`, and the exclusive, sticky, quiet end states. The command bytes, their order, the status and echo checks, the poll timeout edge, the retry limit, the capacity bit and the exact trailing clock count depend on what a card replies. Only the bench scenarios can show these: they run against a card model whose reply delay, status codes, echo pattern, busy count and capacity bit are set per vector.

// File: rtl/sd_spi_init.sv
module sd_spi_init #(
  parameter int CLK_DIV     = 125,
  parameter int PWR_OFF_CYC = 1000000,
  parameter int SPARE_CLKS  = 80,
  parameter int POLL_LIMIT  = 16,
  parameter int ACMD_TRIES  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic miso,
  output logic sclk,
  output logic cs_n,
  output logic mosi,
  output logic pwr_en,
  output logic ready,
  output logic error,
  output logic sdhc
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int TW = $clog2(ACMD_TRIES + 1);
  localparam int SPARE_BYTES = (SPARE_CLKS + 7) / 8;

  typedef enum logic [3:0] {S_OFF, S_SPARE, S_CMD, S_POLL, S_TAIL, S_EVAL, S_TRAIL, S_READY, S_ERR} st_t;

  function automatic logic [47:0] frame(input logic [5:0] idx);
    case (idx)
      6'd0:    frame = {8'h40, 32'h0000_0000, 8'h95};
      6'd8:    frame = {8'h48, 32'h0000_01AA, 8'h87};
      6'd41:   frame = {8'h69, 32'h4000_0000, 8'h01};
      default: frame = {2'b01, idx, 32'h0000_0000, 8'h01};
    endcase
  endfunction

  st_t         state;
  logic [31:0] cnt;
  logic [TW-1:0] tries;
  logic [5:0]  cmd, nxt;
  logic [47:0] frm;
  logic [7:0]  r1;
  logic [31:0] tail;
  logic        ccs, ok;

  logic          busy, sclk_r;
  logic [DW-1:0] divc;
  logic [2:0]    bitc;
  logic [7:0]    txs, rxs;

  wire restart = !rst_n || start;
  wire xfer  = state inside {S_SPARE, S_CMD, S_POLL, S_TAIL, S_TRAIL};
  wire tick  = busy && divc == DW'(CLK_DIV - 1);
  wire bdone = tick && sclk_r && bitc == 3'd7;

  assign sclk   = sclk_r;
  assign mosi   = txs[7];
  assign cs_n   = !(state inside {S_CMD, S_POLL, S_TAIL, S_EVAL});
  assign pwr_en = state != S_OFF;
  assign ready  = state == S_READY;
  assign error  = state == S_ERR;
  assign sdhc   = ccs;

  always_ff @(posedge clk) begin
    if (restart) begin
      busy <= 1'b0; sclk_r <= 1'b0; divc <= '0; bitc <= '0;
      txs <= 8'hFF; rxs <= 8'hFF;
    end else if (!busy) begin
      if (xfer) begin
        busy <= 1'b1; divc <= '0; bitc <= '0;
        txs  <= (state == S_CMD) ? frm[47:40] : 8'hFF;
      end
    end else begin
      divc <= tick ? '0 : divc + 1'b1;
      if (tick) begin
        sclk_r <= !sclk_r;
        if (!sclk_r) rxs <= {rxs[6:0], miso};
        else begin
          txs  <= {txs[6:0], 1'b1};
          bitc <= bitc + 1'b1;
          if (bitc == 3'd7) busy <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    nxt = 6'd0;
    ok  = 1'b0;
    case (cmd)
      6'd0:  begin ok = r1 == 8'h01; nxt = 6'd8; end
      6'd8:  begin ok = r1 == 8'h01 && tail == 32'h0000_01AA; nxt = 6'd55; end
      6'd55: begin ok = r1[7:1] == 7'd0; nxt = 6'd41; end
      6'd41: begin
        ok  = r1 == 8'h00 || (r1 == 8'h01 && tries != TW'(ACMD_TRIES - 1));
        nxt = (r1 == 8'h00) ? 6'd58 : 6'd55;
      end
      6'd58: ok = r1 == 8'h00;
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      state <= S_OFF; cnt <= '0; tries <= '0; cmd <= 6'd0;
      frm <= frame(6'd0); r1 <= 8'hFF; tail <= '0; ccs <= 1'b0;
    end else begin
      case (state)
        S_OFF:
          if (cnt == 32'(PWR_OFF_CYC - 1)) begin state <= S_SPARE; cnt <= '0; end
          else cnt <= cnt + 1;
        S_SPARE:
          if (bdone) begin
            if (cnt == 32'(SPARE_BYTES - 1)) begin
              state <= S_CMD; cnt <= '0; cmd <= 6'd0; frm <= frame(6'd0);
            end else cnt <= cnt + 1;
          end
        S_CMD:
          if (bdone) begin
            frm <= frm << 8;
            if (cnt == 32'd5) begin state <= S_POLL; cnt <= '0; end
            else cnt <= cnt + 1;
          end
        S_POLL:
          if (bdone) begin
            if (rxs != 8'hFF) begin
              r1 <= rxs; cnt <= '0;
              state <= (cmd == 6'd8 || cmd == 6'd58) ? S_TAIL : S_EVAL;
            end else if (cnt == 32'(POLL_LIMIT - 1)) state <= S_ERR;
            else cnt <= cnt + 1;
          end
        S_TAIL:
          if (bdone) begin
            tail <= {tail[23:0], rxs};
            if (cnt == 32'd3) begin state <= S_EVAL; cnt <= '0; end
            else cnt <= cnt + 1;
          end
        S_EVAL:
          if (!ok) state <= S_ERR;
          else if (cmd == 6'd58) begin ccs <= tail[30]; state <= S_TRAIL; end
          else begin
            if (cmd == 6'd41) tries <= tries + 1'b1;
            cmd <= nxt; frm <= frame(nxt); state <= S_CMD;
          end
        S_TRAIL: if (bdone) state <= S_READY;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sd_spi_init_chk.sv
module sd_spi_init_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic pwr_en,
  input logic ready,
  input logic error,
  input logic sdhc
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (cs_n && !sclk));

  assert_cs_needs_power_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> pwr_en);

  assert_mosi_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> mosi);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && error));

  assert_quiet_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || error) |-> (cs_n && !sclk));

  assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!pwr_en && !ready && !error && !sdhc));
endmodule

bind sd_spi_init sd_spi_init_chk u_chk (.*);

// File: tb/sim_sd_spi_init.sv
module sim_sd_spi_init;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2, PWR_OFF = 20, SPARE = 80, POLL = 8, TRIES = 4;

  // {ncr, r1 of idx0, echo pattern, busy count, r1 of idx58, 3'b0, ccs, 1'b0, exp ready, exp error, exp sdhc}
  localparam logic [47:0] TBL [0:8] = '{
    48'h01_01_AA_02_00_15,
    48'h00_01_AA_00_00_04,
    48'h07_01_AA_01_00_15,
    48'h08_01_AA_00_00_12,
    48'h00_05_AA_00_00_02,
    48'h00_01_55_00_00_02,
    48'h00_01_AA_03_00_04,
    48'h00_01_AA_04_00_02,
    48'h00_01_AA_00_04_12
  };
  localparam int EXP_LOG [0:8] = '{0, 8, 55, 41, 55, 41, 55, 41, 58};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sclk, cs_n, mosi, pwr_en, ready, error, sdhc, miso_b;
  int checks = 0, fails = 0;

  sd_spi_init #(.CLK_DIV(DIV), .PWR_OFF_CYC(PWR_OFF), .SPARE_CLKS(SPARE),
                .POLL_LIMIT(POLL), .ACMD_TRIES(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso_b), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .pwr_en(pwr_en), .ready(ready), .error(error), .sdhc(sdhc));

  always #(CLK_PERIOD / 2) clk = !clk;

  // card model configuration and state
  int cfg_ncr = 0, cfg_busy = 0;
  logic [7:0] cfg_r0 = 8'h01, cfg_pat = 8'hAA, cfg_r58 = 8'h00;
  logic cfg_ccs = 1'b0;
  logic [7:0] q [0:31];
  int qh = 0, qt = 0, bc = 0, coll = 0, busy_left = 0, nlog = 0;
  int lg [0:31];
  logic [7:0] rxb = 8'hFF, cur_out = 8'hFF;
  logic [7:0] fb [0:5];
  logic [47:0] f0 = '0, f8 = '0, f41 = '0;
  int spare_cnt = 0, spare_bad = 0, trail = 0;
  bit pend = 1'b1;

  assign miso_b = (!cs_n && pwr_en) ? cur_out[3'(7 - bc)] : 1'b1;

  task automatic push(input logic [7:0] b);
    q[qt % 32] = b; qt++;
  endtask

  task automatic card_byte(input logic [7:0] b);
    logic [47:0] f;
    if (coll == 0) begin
      if (b[7:6] == 2'b01) begin fb[0] = b; coll = 1; end
    end else begin
      fb[coll] = b; coll++;
      if (coll == 6) begin
        coll = 0;
        f = {fb[0], fb[1], fb[2], fb[3], fb[4], fb[5]};
        if (nlog < 32) lg[nlog] = int'(fb[0][5:0]);
        nlog++;
        for (int i = 0; i < cfg_ncr; i++) push(8'hFF);
        case (fb[0][5:0])
          6'd0:  begin f0 = f; push(cfg_r0); end
          6'd8:  begin f8 = f; push(8'h01); push(8'h00); push(8'h00); push(8'h01); push(cfg_pat); end
          6'd55: push(8'h01);
          6'd41: begin
            f41 = f;
            if (busy_left > 0) begin busy_left--; push(8'h01); end else push(8'h00);
          end
          6'd58: begin push(cfg_r58); push({1'b1, cfg_ccs, 6'd0}); push(8'hFF); push(8'h80); push(8'h00); end
          default: push(8'h04);
        endcase
      end
    end
  endtask

  always @(posedge pwr_en) begin
    qh = 0; qt = 0; coll = 0; bc = 0; nlog = 0; busy_left = cfg_busy;
    cur_out = 8'hFF; spare_cnt = 0; spare_bad = 0; pend = 1'b1;
  end

  always @(negedge cs_n) pend = 1'b0;
  always @(posedge cs_n) begin trail = 0; bc = 0; end

  always @(posedge sclk) begin
    if (!cs_n && pwr_en) begin
      rxb = {rxb[6:0], mosi};
      bc = bc + 1;
      if (bc == 8) begin
        bc = 0;
        card_byte(rxb);
        if (qh != qt) begin cur_out = q[qh % 32]; qh++; end
        else cur_out = 8'hFF;
      end
    end
    if (cs_n) begin
      trail++;
      if (pend) begin spare_cnt++; if (mosi !== 1'b1) spare_bad++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!(ready || error) && k < 40000) begin @(negedge clk); k++; end
    chk(ready || error, req, k, 0);
  endtask

  task automatic set_cfg(input logic [47:0] v);
    cfg_ncr = int'(v[47:40]); cfg_r0 = v[39:32]; cfg_pat = v[31:24];
    cfg_busy = int'(v[23:16]); cfg_r58 = v[15:8]; cfg_ccs = v[4];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    bit seq_ok;
    set_cfg(TBL[0]);
    repeat (4) @(negedge clk);
    chk(!pwr_en, "R1 reset pwr_en", int'(pwr_en), 0);
    chk(cs_n && !sclk, "R1 reset bus idle", int'({cs_n, sclk}), 2);
    chk(!ready && !error && !sdhc, "R10 reset status", int'({ready, error, sdhc}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      set_cfg(TBL[i]);
      pulse_start();
      n = 0;
      while (!pwr_en && n < 1000) begin n++; @(negedge clk); end
      if (i == 0) chk(n >= PWR_OFF && n <= PWR_OFF + 1, "R1 power-off length", n, PWR_OFF);
      wait_done("R5 sequence finished");
      chk(ready == TBL[i][2], $sformatf("R9 row %0d ready", i), int'(ready), int'(TBL[i][2]));
      chk(error == TBL[i][1], $sformatf("R5 R6 R7 R8 row %0d error", i), int'(error), int'(TBL[i][1]));
      chk(sdhc == TBL[i][0], $sformatf("R9 row %0d sdhc", i), int'(sdhc), int'(TBL[i][0]));
      if (i == 0) begin
        chk(spare_cnt >= SPARE && spare_bad == 0, "R2 spare clocks", spare_cnt, SPARE);
        chk(f0 == 48'h40_0000_0000_95, "R3 reset command frame", int'(f0[31:0]), 32'h0000_0095);
        chk(f8 == 48'h48_0000_01AA_87, "R4 voltage command frame", int'(f8[31:0]), 32'h0001_AA87);
        chk(f41[39:8] == 32'h4000_0000, "R4 operating condition argument", int'(f41[39:8]), 32'h4000_0000);
        seq_ok = (nlog == 9);
        for (int j = 0; j < 9 && j < nlog; j++) if (lg[j] != EXP_LOG[j]) seq_ok = 1'b0;
        chk(seq_ok, "R4 R8 command order", nlog, 9);
        chk(trail == 8, "R9 trailing clocks", trail, 8);
      end
    end

    set_cfg(TBL[0]);
    pulse_start();
    repeat (200) @(negedge clk);
    pulse_start();
    chk(!pwr_en && !ready && !error, "R11 restart during init", int'({pwr_en, ready, error}), 0);
    wait_done("R11 rerun finished");
    chk(ready && sdhc, "R11 rerun result", int'({ready, sdhc}), 3);
    pulse_start();
    chk(!sdhc && !ready, "R11 discards capacity", int'({sdhc, ready}), 0);

    set_cfg(TBL[4]);
    pulse_start();
    wait_done("R6 bad reset reply");
    seq_ok = 1'b1;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (!(cs_n && !sclk && error && !ready)) seq_ok = 1'b0;
    end
    chk(seq_ok, "R10 quiet sticky error", int'(error), 1);

    set_cfg(TBL[1]);
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!pwr_en && cs_n && !error, "R1 reset mid-run", int'({pwr_en, cs_n, error}), 2);
    rst_n = 1'b1;
    wait_done("R1 init after reset");
    chk(ready && !sdhc, "R1 ready after reset", int'({ready, sdhc}), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule